// File: doc/BRIEF.md
# Stereo Audio Serial Output Port

This block takes stereo pairs of 24-bit conversion results and sends them out on a three-wire audio serial link. The link has a bit clock, a word (channel) clock and a data line. A pair arrives on a parallel bus with a one-cycle strobe and is held in a shadow store. The pair is moved into the active store only when a left-channel half begins. Because of this, the left and right words sent in one frame always belong to the same pair.

In clock-master operation the system clock is the 256x master clock. The block divides it by 4 to make the bit clock and by 256 to make the word clock. Each channel half therefore lasts 32 bit periods. In clock-slave operation both clocks come from outside. They are synchronized into the system clock domain, and their edges drive the same slot logic. A format input picks left-justified framing or I2S framing, where the MSB comes one bit later. Data is MSB first, and the 8 slots after each word are sent low.

Top module: `asp_serial_port`

## Requirements
- R1: Each frame carries one 24-bit left word, then one 24-bit right word, each sent MSB first, one bit per bit-clock period.
- R2: In master mode (`slave_mode`=0), `sclk_out` has a period of 4 system clocks, high for 2 and low for 2. Each word-clock half holds exactly 32 `sclk_out` periods.
- R3: In master mode, `sdata` and `lrck_out` change only in the cycle where `sclk_out` falls.
- R4: With `fmt_i2s`=0, a high word clock marks the left channel. The MSB is in the first slot after the word-clock transition.
- R5: With `fmt_i2s`=1, a low word clock marks the left channel. Slot 0 of each half is low and the MSB is in slot 1.
- R6: Every slot of a half that holds no data bit is driven low. These are the slots after the 24 data bits, and slot 0 with `fmt_i2s`=1.
- R7: A pair strobed in with `pair_valid` goes out starting with the next left half. A strobe that arrives during a left half does not change the right word of that frame.
- R8: If several pairs are strobed before a left half begins, only the last one is sent. If no pair is strobed, the previous pair is sent again.
- R9: In slave mode (`slave_mode`=1), `sclk_in` and `lrck_in` set the framing. A word-clock edge starts slot 0 and each bit-clock fall advances one slot. Data is sampled correctly on rising `sclk_in`, and `sclk_out` and `lrck_out` are held low.
- R10: After synchronous reset, `sclk_out` and `sdata` are low and the master word clock is at its left level. Both stored pairs are zero, so zero words are sent until a pair arrives.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock; the 256x master clock in master mode |
| rst | input | 1 | Synchronous active-high reset |
| slave_mode | input | 1 | 1: clocks from outside; 0: clocks generated |
| fmt_i2s | input | 1 | 1: I2S framing; 0: left-justified |
| pair_valid | input | 1 | One-cycle strobe that loads a stereo pair |
| pair_left | input | 24 | Left-channel word |
| pair_right | input | 24 | Right-channel word |
| sclk_in | input | 1 | External bit clock (slave mode) |
| lrck_in | input | 1 | External word clock (slave mode) |
| sclk_out | output | 1 | Generated bit clock (master mode) |
| lrck_out | output | 1 | Generated word clock (master mode) |
| sdata | output | 1 | Serial data |

## Verification
A slot position that is off by one shows up in the very next half. The received word comes out shifted by one bit, and a data bit lands in a pad slot. A wrong divider count breaks the bit-clock period within 4 system clocks and breaks the 32-slot half length within one half. A wrong state in the pair stores shows within one frame, as a word from the wrong pair, a stale word or a pair split across frames. The bench therefore decodes every half like a receiver and checks it against the pair that should have been sent.

// File: rtl/asp_pkg.sv
package asp_pkg;

    localparam int SAMPLE_W   = 24;
    localparam int HALF_SLOTS = 32;
    localparam int SCLK_DIV   = 4;

    typedef enum logic {
        CH_RIGHT = 1'b0,
        CH_LEFT  = 1'b1
    } chan_e;

    // One slot event: a bit-clock fall, possibly opening a new channel half
    typedef struct packed {
        logic  step;
        logic  half_start;
        chan_e chan;
    } slot_evt_t;

    // Word-clock level that marks a channel for the chosen framing
    function automatic logic lrck_level(input chan_e ch, input logic i2s);
        return (ch == CH_LEFT) ^ i2s;
    endfunction

    // Channel marked by a word-clock level for the chosen framing
    function automatic chan_e chan_of_level(input logic level, input logic i2s);
        return (level ^ i2s) ? CH_LEFT : CH_RIGHT;
    endfunction

endpackage

// File: rtl/asp_master_clkgen.sv
module asp_master_clkgen
    import asp_pkg::*;
#(
    parameter int HALF_SLOTS = 32,
    parameter int SCLK_DIV   = 4
) (
    input  logic      clk,
    input  logic      rst,
    input  logic      en,
    input  logic      fmt_i2s,
    output slot_evt_t evt,
    output logic      sclk_o,
    output logic      lrck_o
);
    localparam int DIV_W  = (SCLK_DIV > 2) ? $clog2(SCLK_DIV) : 1;
    localparam int HALF_W = $clog2(HALF_SLOTS);
    localparam int SLOT_W = HALF_W + 1;
    localparam logic [DIV_W-1:0] DIV_LAST = DIV_W'(SCLK_DIV - 1);
    localparam logic [DIV_W-1:0] DIV_HIGH = DIV_W'(SCLK_DIV / 2);

    logic [DIV_W-1:0]  div_q, div_nx;
    logic [SLOT_W-1:0] slot_q, slot_nx;
    logic              step;

    always_comb begin
        div_nx         = (div_q == DIV_LAST) ? '0 : div_q + 1'b1;
        step           = en && (div_q == DIV_LAST);
        slot_nx        = slot_q + 1'b1;
        evt.step       = step;
        evt.half_start = step && (slot_nx[HALF_W-1:0] == '0);
        evt.chan       = slot_nx[SLOT_W-1] ? CH_RIGHT : CH_LEFT;
    end

    always_ff @(posedge clk) begin
        if (rst || !en) begin
            div_q  <= '0;
            slot_q <= '0;
            sclk_o <= 1'b0;
            lrck_o <= en & ~fmt_i2s;
        end else begin
            div_q  <= div_nx;
            sclk_o <= (div_nx >= DIV_HIGH);
            if (step) begin
                slot_q <= slot_nx;
            end
            if (evt.half_start) begin
                lrck_o <= lrck_level(evt.chan, fmt_i2s);
            end
        end
    end

endmodule

// File: rtl/asp_slave_sync.sv
module asp_slave_sync
    import asp_pkg::*;
#(
    parameter int SYNC_STAGES = 2
) (
    input  logic      clk,
    input  logic      rst,
    input  logic      en,
    input  logic      fmt_i2s,
    input  logic      sclk_in,
    input  logic      lrck_in,
    output slot_evt_t evt
);
    localparam int NSIG = 2;

    logic [NSIG-1:0] raw;
    logic [NSIG-1:0] cur;
    logic [NSIG-1:0] prev;

    assign raw = {lrck_in, sclk_in};

    for (genvar g = 0; g < NSIG; g++) begin : g_sync
        logic [SYNC_STAGES:0] pipe;
        always_ff @(posedge clk) begin
            if (rst) begin
                pipe <= '0;
            end else begin
                pipe <= {pipe[SYNC_STAGES-1:0], raw[g]};
            end
        end
        assign cur[g]  = pipe[SYNC_STAGES-1];
        assign prev[g] = pipe[SYNC_STAGES];
    end

    // index 0: bit clock, index 1: word clock
    always_comb begin
        evt.half_start = en && (cur[1] != prev[1]);
        evt.step       = en && prev[0] && !cur[0];
        evt.chan       = chan_of_level(cur[1], fmt_i2s);
    end

endmodule

// File: rtl/asp_pair_buffer.sv
module asp_pair_buffer
    import asp_pkg::*;
#(
    parameter int SAMPLE_W = 24
) (
    input  logic                clk,
    input  logic                rst,
    input  logic                pair_valid,
    input  logic [SAMPLE_W-1:0] pair_left,
    input  logic [SAMPLE_W-1:0] pair_right,
    input  slot_evt_t           evt,
    output logic [SAMPLE_W-1:0] load_word
);
    logic [SAMPLE_W-1:0] shadow_l, shadow_r;
    logic [SAMPLE_W-1:0] active_l, active_r;
    logic                shadow_full;
    logic                take;

    assign take = evt.half_start && (evt.chan == CH_LEFT) && shadow_full;

    always_comb begin
        if (evt.chan == CH_LEFT) begin
            load_word = shadow_full ? shadow_l : active_l;
        end else begin
            load_word = active_r;
        end
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            shadow_l    <= '0;
            shadow_r    <= '0;
            active_l    <= '0;
            active_r    <= '0;
            shadow_full <= 1'b0;
        end else begin
            if (take) begin
                active_l <= shadow_l;
                active_r <= shadow_r;
            end
            if (pair_valid) begin
                shadow_l    <= pair_left;
                shadow_r    <= pair_right;
                shadow_full <= 1'b1;
            end else if (take) begin
                shadow_full <= 1'b0;
            end
        end
    end

endmodule

// File: rtl/asp_bit_serializer.sv
module asp_bit_serializer
    import asp_pkg::*;
#(
    parameter int SAMPLE_W   = 24,
    parameter int HALF_SLOTS = 32
) (
    input  logic                clk,
    input  logic                rst,
    input  logic                fmt_i2s,
    input  slot_evt_t           evt,
    input  logic [SAMPLE_W-1:0] load_word,
    output logic                sdata_o
);
    localparam int POS_W = $clog2(HALF_SLOTS);
    localparam logic [POS_W-1:0] POS_LAST = POS_W'(HALF_SLOTS - 1);

    logic [POS_W-1:0]    pos_q, pos_nx;
    logic [SAMPLE_W-1:0] word_q, word_nx;
    logic                upd;

    function automatic logic slot_bit(input logic [SAMPLE_W-1:0] w,
                                      input int pos, input logic i2s);
        int                  d;
        logic [SAMPLE_W-1:0] t;
        d = i2s ? pos - 1 : pos;
        if (d < 0 || d >= SAMPLE_W) begin
            return 1'b0;
        end
        t = w << d;
        return t[SAMPLE_W-1];
    endfunction

    always_comb begin
        upd     = evt.half_start || evt.step;
        pos_nx  = pos_q;
        word_nx = word_q;
        if (evt.half_start) begin
            pos_nx  = '0;
            word_nx = load_word;
        end else if (evt.step && pos_q != POS_LAST) begin
            pos_nx = pos_q + 1'b1;
        end
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            pos_q   <= '0;
            word_q  <= '0;
            sdata_o <= 1'b0;
        end else if (upd) begin
            pos_q   <= pos_nx;
            word_q  <= word_nx;
            sdata_o <= slot_bit(word_nx, int'(pos_nx), fmt_i2s);
        end
    end

endmodule

// File: rtl/asp_serial_port.sv
module asp_serial_port
    import asp_pkg::*;
#(
    parameter int SAMPLE_W    = asp_pkg::SAMPLE_W,
    parameter int HALF_SLOTS  = asp_pkg::HALF_SLOTS,
    parameter int SCLK_DIV    = asp_pkg::SCLK_DIV,
    parameter int SYNC_STAGES = 2
) (
    input  logic                clk,
    input  logic                rst,
    input  logic                slave_mode,
    input  logic                fmt_i2s,
    input  logic                pair_valid,
    input  logic [SAMPLE_W-1:0] pair_left,
    input  logic [SAMPLE_W-1:0] pair_right,
    input  logic                sclk_in,
    input  logic                lrck_in,
    output logic                sclk_out,
    output logic                lrck_out,
    output logic                sdata
);
    slot_evt_t           evt_m, evt_s, evt;
    logic [SAMPLE_W-1:0] load_word;

    asp_master_clkgen #(
        .HALF_SLOTS(HALF_SLOTS),
        .SCLK_DIV  (SCLK_DIV)
    ) u_clkgen (
        .clk    (clk),
        .rst    (rst),
        .en     (!slave_mode),
        .fmt_i2s(fmt_i2s),
        .evt    (evt_m),
        .sclk_o (sclk_out),
        .lrck_o (lrck_out)
    );

    asp_slave_sync #(
        .SYNC_STAGES(SYNC_STAGES)
    ) u_sync (
        .clk    (clk),
        .rst    (rst),
        .en     (slave_mode),
        .fmt_i2s(fmt_i2s),
        .sclk_in(sclk_in),
        .lrck_in(lrck_in),
        .evt    (evt_s)
    );

    assign evt = slave_mode ? evt_s : evt_m;

    asp_pair_buffer #(
        .SAMPLE_W(SAMPLE_W)
    ) u_buffer (
        .clk       (clk),
        .rst       (rst),
        .pair_valid(pair_valid),
        .pair_left (pair_left),
        .pair_right(pair_right),
        .evt       (evt),
        .load_word (load_word)
    );

    asp_bit_serializer #(
        .SAMPLE_W  (SAMPLE_W),
        .HALF_SLOTS(HALF_SLOTS)
    ) u_ser (
        .clk      (clk),
        .rst      (rst),
        .fmt_i2s  (fmt_i2s),
        .evt      (evt),
        .load_word(load_word),
        .sdata_o  (sdata)
    );

endmodule

// File: rtl/asp_checker.sv
module asp_checker #(
    parameter int W    = 24,
    parameter int HALF = 32
) (
    input logic clk,
    input logic rst,
    input logic slave_mode,
    input logic fmt_i2s,
    input logic sclk_out,
    input logic lrck_out,
    input logic sdata
);
    localparam logic [7:0] HALF_LAST = 8'(HALF - 1);
    localparam logic [7:0] PAD_LJ    = 8'(W);
    localparam logic [7:0] PAD_I2S   = 8'(W + 1);

    logic       sclk_d, lrck_d, sdata_d, primed;
    logic [7:0] nfall;
    logic       fall_now, lrck_moved;

    assign fall_now   = sclk_d && !sclk_out;
    assign lrck_moved = lrck_out != lrck_d;

    always_ff @(posedge clk) begin
        if (rst) begin
            sclk_d  <= 1'b0;
            lrck_d  <= !slave_mode && !fmt_i2s;
            sdata_d <= 1'b0;
            nfall   <= '0;
            primed  <= 1'b0;
        end else begin
            sclk_d  <= sclk_out;
            lrck_d  <= lrck_out;
            sdata_d <= sdata;
            if (lrck_moved) begin
                nfall  <= '0;
                primed <= 1'b1;
            end else if (fall_now && nfall != 8'hFF) begin
                nfall <= nfall + 1'b1;
            end
        end
    end

    a_r3_sdata_on_fall: assert property (@(posedge clk) disable iff (rst)
        (!slave_mode && sdata != sdata_d) |-> fall_now);

    a_r3_lrck_on_fall: assert property (@(posedge clk) disable iff (rst)
        (!slave_mode && lrck_moved) |-> fall_now);

    a_r2_half_length: assert property (@(posedge clk) disable iff (rst)
        (!slave_mode && primed && lrck_moved) |-> nfall == HALF_LAST);

    a_r6_pad_low: assert property (@(posedge clk) disable iff (rst)
        (!slave_mode && primed && !lrck_moved &&
         nfall >= (fmt_i2s ? PAD_I2S : PAD_LJ)) |-> !sdata);

    a_r5_i2s_lead_low: assert property (@(posedge clk) disable iff (rst)
        (!slave_mode && fmt_i2s && lrck_moved) |-> !sdata);

    a_r9_slave_clocks_low: assert property (@(posedge clk) disable iff (rst)
        slave_mode |-> (!sclk_out && !lrck_out));

endmodule

bind asp_serial_port asp_checker #(
    .W   (SAMPLE_W),
    .HALF(HALF_SLOTS)
) u_checker (
    .clk       (clk),
    .rst       (rst),
    .slave_mode(slave_mode),
    .fmt_i2s   (fmt_i2s),
    .sclk_out  (sclk_out),
    .lrck_out  (lrck_out),
    .sdata     (sdata)
);

// File: tb/asp_serial_port_tb.sv
module asp_serial_port_tb;

    typedef struct {
        bit          left;
        logic [23:0] word;
        string       tag;
    } exp_t;

    logic        clk = 0;
    logic        rst = 1;
    logic        slave_mode = 0;
    logic        fmt_i2s = 0;
    logic        pair_valid = 0;
    logic [23:0] pair_left = '0;
    logic [23:0] pair_right = '0;
    logic        sclk_in = 1;
    logic        lrck_in = 0;
    logic        sclk_out, lrck_out, sdata;

    always #10 clk = ~clk;

    asp_serial_port u_dut (
        .clk(clk), .rst(rst), .slave_mode(slave_mode), .fmt_i2s(fmt_i2s),
        .pair_valid(pair_valid), .pair_left(pair_left), .pair_right(pair_right),
        .sclk_in(sclk_in), .lrck_in(lrck_in),
        .sclk_out(sclk_out), .lrck_out(lrck_out), .sdata(sdata)
    );

    exp_t        q[$];
    int          checks = 0;
    int          errors = 0;
    int          right_starts = 0;
    int          left_starts = 0;
    bit          mon_en = 0;
    bit          slave_run = 0;
    bit          gen_idle = 1;
    bit          finished = 0;
    logic [23:0] last_l = '0, last_r = '0;
    string       mode_tag = "R4";

    task automatic check(input bit ok, input string req, input string what,
                         input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s %s actual=%h expected=%h", req, what, act, exp);
        end
    endtask

    task automatic summary();
        if (!finished) begin
            finished = 1;
            $display("Simulation finished: %0d checks, %0d errors", checks, errors);
            $finish;
        end
    endtask

    // ---------------- monitor: receiver-side decode ----------------
    logic        prev_sclk, last_lrck, prev_sdata, prev_lrck_o;
    bit          in_half, half_left, armed, pad_ok, clk_ok, edge_ok, quiet_ok, rise_seen;
    int          slot, gap, hi;
    logic [23:0] acc;

    task automatic finalize();
        if (!slave_mode) begin
            check(slot == 32, "R2", "slots per half", slot, 32);
            check(clk_ok, "R2", "sclk period/duty", clk_ok, 1);
            check(edge_ok, "R3", "sdata/lrck change off sclk fall", edge_ok, 1);
        end else begin
            check(quiet_ok, "R9", "clock outputs low in slave", quiet_ok, 1);
        end
        check(pad_ok, "R6", "non-data slots low", pad_ok, 1);
        if (armed) begin
            if (q.size() == 0) begin
                check(0, "R1", "unexpected half", acc, 0);
            end else begin
                exp_t e;
                e = q.pop_front();
                check(e.left == half_left, "R1", "channel order", half_left, e.left);
                check(e.word == acc, e.tag, "received word", acc, e.word);
            end
        end
    endtask

    always @(negedge clk) begin
        logic s, l;
        s = slave_mode ? sclk_in : sclk_out;
        l = slave_mode ? lrck_in : lrck_out;
        if (!mon_en) begin
            in_half = 0; rise_seen = 0; gap = 0; hi = 0;
            last_lrck = l;
        end else begin
            if (!slave_mode) begin
                if ((sdata !== prev_sdata || lrck_out !== prev_lrck_o) && !(prev_sclk && !s))
                    edge_ok = 0;
            end else if (sclk_out || lrck_out) begin
                quiet_ok = 0;
            end
            gap++;
            if (s) hi++;
            if (s && !prev_sclk) begin
                if (!slave_mode && rise_seen && (gap != 4 || hi != 2)) clk_ok = 0;
                rise_seen = 1; gap = 0; hi = 0;
                if (l !== last_lrck) begin
                    if (in_half) finalize();
                    in_half   = 1;
                    half_left = fmt_i2s ? !l : l;
                    slot = 0; acc = '0;
                    pad_ok = 1; clk_ok = 1; edge_ok = 1; quiet_ok = 1;
                    armed = q.size() > 0;
                    last_lrck = l;
                    if (half_left) left_starts++; else right_starts++;
                end
                if (in_half) begin
                    int d;
                    d = fmt_i2s ? slot - 1 : slot;
                    if (d >= 0 && d < 24) acc = {acc[22:0], sdata};
                    else if (sdata) pad_ok = 0;
                    slot++;
                end
            end
        end
        prev_sclk = s; prev_sdata = sdata; prev_lrck_o = lrck_out;
    end

    // ---------------- slave clock generator ----------------
    initial begin
        forever begin
            if (slave_run) begin
                gen_idle = 0;
                for (int h = 0; h < 2; h++) begin
                    for (int k = 0; k < 32; k++) begin
                        @(negedge clk);
                        sclk_in = 0;
                        if (k == 0) lrck_in = (h == 0) ? !fmt_i2s : fmt_i2s;
                        repeat (8) @(negedge clk);
                        sclk_in = 1;
                        repeat (7) @(negedge clk);
                    end
                end
            end else begin
                gen_idle = 1;
                @(negedge clk);
            end
        end
    end

    // ---------------- driver tasks ----------------
    task automatic wait_right();
        int n;
        n = right_starts;
        wait (right_starts != n);
    endtask

    task automatic wait_left();
        int n;
        n = left_starts;
        wait (left_starts != n);
    endtask

    task automatic strobe(input logic [23:0] l, input logic [23:0] r);
        @(negedge clk);
        pair_valid = 1; pair_left = l; pair_right = r;
        @(negedge clk);
        pair_valid = 0; pair_left = '0; pair_right = '0;
    endtask

    task automatic send_pair(input logic [23:0] l, input logic [23:0] r, input string tag);
        wait_right();
        repeat (20) @(negedge clk);
        strobe(l, r);
        q.push_back('{1'b1, l, tag});
        q.push_back('{1'b0, r, tag});
        last_l = l; last_r = r;
    endtask

    task automatic repeat_pair();   // R8: no strobe, same pair again
        wait_right();
        q.push_back('{1'b1, last_l, "R8"});
        q.push_back('{1'b0, last_r, "R8"});
    endtask

    task automatic double_strobe(input logic [23:0] l1, input logic [23:0] r1,
                                 input logic [23:0] l2, input logic [23:0] r2);
        wait_right();
        repeat (10) @(negedge clk);
        strobe(l1, r1);
        repeat (10) @(negedge clk);
        strobe(l2, r2);
        q.push_back('{1'b1, l2, "R8"});
        q.push_back('{1'b0, r2, "R8"});
        last_l = l2; last_r = r2;
    endtask

    task automatic left_strobe(input logic [23:0] l, input logic [23:0] r);
        // R7: strobe mid left half; this frame's right word stays the old one
        wait_left();
        repeat (20) @(negedge clk);
        strobe(l, r);
        q.push_back('{1'b1, l, "R7"});
        q.push_back('{1'b0, r, "R7"});
        last_l = l; last_r = r;
        wait_right();
    endtask

    task automatic drain();
        wait (q.size() == 0);
        repeat (4) @(negedge clk);
    endtask

    task automatic start_cfg(input bit slv, input bit i2s);
        mon_en = 0;
        slave_run = 0;
        wait (gen_idle);
        @(negedge clk);
        rst = 1; slave_mode = slv; fmt_i2s = i2s;
        sclk_in = 1; lrck_in = i2s;
        repeat (5) @(negedge clk);
        rst = 0;
        last_l = '0; last_r = '0;
        mon_en = 1;
        slave_run = slv;
    endtask

    // ---------------- watchdog ----------------
    initial begin
        repeat (150000) @(posedge clk);
        errors++;
        $display("FAIL watchdog expired, run did not complete");
        summary();
    end

    // ---------------- main sequence ----------------
    initial begin
        // master, left-justified
        mode_tag = "R4";
        start_cfg(0, 0);
        #1;
        check(sclk_out == 0, "R10", "sclk_out after reset", sclk_out, 0);
        check(sdata == 0, "R10", "sdata after reset", sdata, 0);
        check(lrck_out == 1, "R10", "lrck_out left level after reset", lrck_out, 1);
        q.push_back('{1'b0, 24'h000000, "R10"});
        send_pair(24'h800001, 24'h7FFFFE, "R4");
        send_pair(24'hA5A5A5, 24'h5A5A5A, "R1");
        repeat_pair();
        double_strobe(24'h111111, 24'h222222, 24'h123456, 24'hFEDCBA);
        left_strobe(24'hC0FFEE, 24'h0BEEF0);
        send_pair(24'hFFFFFF, 24'h000001, "R4");
        drain();

        // master, I2S framing
        start_cfg(0, 1);
        #1;
        check(lrck_out == 0, "R10", "lrck_out left level after reset (I2S)", lrck_out, 0);
        send_pair(24'h800001, 24'hFFFFFF, "R5");
        send_pair(24'h13579B, 24'h2468AC, "R5");
        double_strobe(24'h0F0F0F, 24'hF0F0F0, 24'hABCDEF, 24'h654321);
        drain();

        // slave, left-justified
        start_cfg(1, 0);
        send_pair(24'h800001, 24'h7FFFFE, "R9");
        send_pair(24'h3C3C3C, 24'hC3C3C3, "R9");
        drain();

        // slave, I2S framing
        start_cfg(1, 1);
        send_pair(24'hFFFFFF, 24'h800000, "R9");
        send_pair(24'h0A0B0C, 24'hD0E0F0, "R9");
        drain();

        summary();
    end

endmodule